// File: doc/BRIEF.md
# Display Control Bus Master

This block lets a host reach up to sixteen slave devices on a narrow, byte-wide control bus. The host first writes a 32-bit mode word that chooses the slave, a 3-bit register select, the number of bytes per access, the handshake style, the byte order and the chip-select timing. A write of the data word then sends one to four bytes to the slave. A read request fetches one to four bytes and leaves them in the data word. Bytes are moved starting at the most significant end of the word.

Each byte passes through three timed phases. The setup phase presents the slave address, the register select and the data byte. The strobe phase asserts chip select, and with the asynchronous handshake it also waits for the slave's acknowledge. The hold phase keeps address and data steady after chip select drops. A busy output is high for the whole transfer, and software polls it before the next access. If an acknowledge never arrives, a timeout aborts the transfer and raises a sticky error flag.

Top module: `dispbus_master`

## Requirements
- R1: After reset, busy, error and chip select are low, bus_rnw is low and the data word reads 0.
- R2: The number of bytes per access comes from mode[1:0]: codes 1, 2 and 3 give that many bytes and code 0 gives 4. When mode[2] (pack) is set, 4 bytes move whatever the code.
- R3: A write sends bytes from data bits [31:24] downward, in order. When mode[28] (swap) is set, the order is reversed and bytes start at bits [7:0].
- R4: A read shifts the received bytes in so that the first byte lands highest, top-aligned in the data word, with the unused low bits zero. With mode[28] set, the data word holds the byte-reversed image of that value.
- R5: The three timing fields are setup at mode[27:23], strobe at mode[17:13] and hold at mode[22:18]. Each phase lasts its field value plus one cycle, so a transfer of n bytes keeps busy high for n*(setup+strobe+hold+3) cycles, and chip select is high for strobe+1 cycles per byte.
- R6: When mode[3] is set, the register select at mode[6:4] (bus_regsel) increments by one, modulo 8, after each completed byte. When mode[3] is clear, it stays constant.
- R7: Slave address 15 (mode[10:7]) is reserved. The transfer runs its full timing but chip select is never asserted.
- R8: With mode[12] set (asynchronous acknowledge), chip select stays high past its strobe count until bus_ack is sampled high. Chip select then drops at that edge.
- R9: If an asynchronous acknowledge has not come ACK_TIMEOUT cycles after the strobe count is met, the transfer aborts. Chip select and busy drop and err rises. err stays set until the next transfer starts, and that start clears it.
- R10: Busy is high from the start edge until the transfer ends. Mode writes, data writes and read requests made while busy is high are ignored.
- R11: bus_rnw is high for a read and low for a write, and it stays constant through the transfer. bus_dout does not change while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Write strobe for the mode word |
| mode_wdata | input | 32 | Mode word value |
| data_we | input | 1 | Write of the data word; starts a bus write |
| data_wdata | input | 32 | Data word value to send |
| data_re | input | 1 | Starts a bus read |
| data_rdata | output | 32 | Data word (last written value or read result) |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Last transfer aborted on acknowledge timeout |
| bus_slave | output | 4 | Slave address on the bus |
| bus_regsel | output | 3 | Register select on the bus |
| bus_rnw | output | 1 | High for a read transfer |
| bus_cs | output | 1 | Chip select strobe |
| bus_dout | output | 8 | Byte driven to the slave |
| bus_din | input | 8 | Byte returned by the slave |
| bus_ack | input | 1 | Slave acknowledge |

## Verification
The checker watches several properties on every cycle. It confirms that chip select never rises for the reserved slave and that chip select only appears while busy. It checks that slave address, direction and driven byte stay steady when they must, that an asynchronous strobe only ends on a sampled acknowledge unless the transfer aborts, and that error and busy are never high together. Other properties need the directed scenarios to show them: byte order in both directions, the byte count under each width and pack setting, phase lengths, register-select wrap, the timeout abort, and writes ignored while busy.

// File: rtl/dispbus_pkg.sv
package dispbus_pkg;

  localparam int CNT_W = 5;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_t;

  typedef struct packed {
    logic [2:0]       rsvd;
    logic             swap;
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] hold;
    logic [CNT_W-1:0] width;
    logic             ack_async;
    logic             ack_sync;
    logic [3:0]       slave;
    logic [2:0]       regsel;
    logic             auto_inc;
    logic             pack;
    logic [1:0]       bsize;
  } mode_t;

  function automatic logic [2:0] xfer_bytes(input mode_t m);
    if (m.pack || (m.bsize == 2'd0)) return 3'd4;
    return {1'b0, m.bsize};
  endfunction

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] align_read(input logic [31:0] acc,
                                             input logic [2:0]  n,
                                             input logic        swap);
    logic [31:0] t;
    case (n)
      3'd1:    t = {acc[7:0], 24'h0};
      3'd2:    t = {acc[15:0], 16'h0};
      3'd3:    t = {acc[23:0], 8'h0};
      default: t = acc;
    endcase
    return swap ? bswap32(t) : t;
  endfunction

endpackage

// File: rtl/dispbus_seq.sv
module dispbus_seq
  import dispbus_pkg::*;
#(
  parameter int ACK_TIMEOUT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] setup_cnt,
  input  logic [CNT_W-1:0] width_cnt,
  input  logic [CNT_W-1:0] hold_cnt,
  input  logic [2:0]       nbytes,
  input  logic             ack_async,
  input  logic             bus_ack,
  output phase_t           phase,
  output logic             strobe_exit,
  output logic             byte_done,
  output logic             xfer_done,
  output logic             abort
);

  localparam int WT_W = $clog2(ACK_TIMEOUT + 1);

  phase_t           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WT_W-1:0]  wait_q;
  logic [2:0]       bidx_q;
  logic             width_met;
  logic             last_byte;

  always_comb begin
    width_met   = (cnt_q >= width_cnt);
    last_byte   = (bidx_q == (nbytes - 3'd1));
    strobe_exit = (ph_q == PH_STROBE) && width_met && (!ack_async || bus_ack);
    abort       = (ph_q == PH_STROBE) && width_met && ack_async && !bus_ack &&
                  (wait_q == WT_W'(ACK_TIMEOUT - 1));
    byte_done   = (ph_q == PH_HOLD) && (cnt_q == hold_cnt);
    xfer_done   = byte_done && last_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      wait_q <= '0;
      bidx_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (start) begin
            ph_q   <= PH_SETUP;
            cnt_q  <= '0;
            bidx_q <= '0;
          end
        end
        PH_SETUP: begin
          if (cnt_q == setup_cnt) begin
            ph_q   <= PH_STROBE;
            cnt_q  <= '0;
            wait_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_STROBE: begin
          if (abort) begin
            ph_q <= PH_IDLE;
          end else if (strobe_exit) begin
            ph_q  <= PH_HOLD;
            cnt_q <= '0;
          end else if (!width_met) begin
            cnt_q <= cnt_q + 1'b1;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        PH_HOLD: begin
          if (byte_done) begin
            cnt_q <= '0;
            if (last_byte) begin
              ph_q <= PH_IDLE;
            end else begin
              ph_q   <= PH_SETUP;
              bidx_q <= bidx_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase = ph_q;

endmodule

// File: rtl/dispbus_dpath.sv
module dispbus_dpath
  import dispbus_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_read,
  input  logic [31:0] wdata,
  input  logic        swap,
  input  logic [2:0]  nbytes,
  input  logic        capture,
  input  logic        shift,
  input  logic        done,
  input  logic [7:0]  bus_din,
  output logic [7:0]  bus_dout,
  output logic [31:0] rdata
);

  logic [31:0] sh_q;
  logic [31:0] rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= '0;
      rd_q <= '0;
    end else begin
      if (start) begin
        if (is_read) begin
          sh_q <= '0;
        end else begin
          sh_q <= swap ? bswap32(wdata) : wdata;
          rd_q <= wdata;
        end
      end else begin
        if (capture && is_read) sh_q <= {sh_q[23:0], bus_din};
        if (shift && !is_read)  sh_q <= {sh_q[23:0], 8'h00};
        if (done && is_read)    rd_q <= align_read(sh_q, nbytes, swap);
      end
    end
  end

  assign bus_dout = sh_q[31:24];
  assign rdata    = rd_q;

endmodule

// File: rtl/dispbus_master.sv
module dispbus_master
  import dispbus_pkg::*;
#(
  parameter int ACK_TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_we,
  input  logic [31:0] mode_wdata,
  input  logic        data_we,
  input  logic [31:0] data_wdata,
  input  logic        data_re,
  output logic [31:0] data_rdata,
  output logic        busy,
  output logic        err,
  output logic [3:0]  bus_slave,
  output logic [2:0]  bus_regsel,
  output logic        bus_rnw,
  output logic        bus_cs,
  output logic [7:0]  bus_dout,
  input  logic [7:0]  bus_din,
  input  logic        bus_ack
);

  localparam logic [3:0] SLAVE_RSVD = 4'hF;

  mode_t      mode_q;
  phase_t     phase;
  logic       rnw_q;
  logic       err_q;
  logic       start_w;
  logic       start_rd_w;
  logic       strobe_exit_w;
  logic       byte_done_w;
  logic       xfer_done_w;
  logic       abort_w;
  logic       async_mode;
  logic [2:0] nbytes_w;
  logic       unused_bits;

  assign busy        = (phase != PH_IDLE);
  assign start_w     = !busy && (data_we || data_re);
  assign start_rd_w  = !data_we;
  assign async_mode  = mode_q.ack_async;
  assign nbytes_w    = xfer_bytes(mode_q);
  assign unused_bits = ^{mode_q.rsvd, mode_q.ack_sync};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      rnw_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (mode_we && !busy) mode_q <= mode_t'(mode_wdata);
      else if (byte_done_w && mode_q.auto_inc) mode_q.regsel <= mode_q.regsel + 3'd1;
      if (start_w) begin
        rnw_q <= start_rd_w;
        err_q <= 1'b0;
      end else if (abort_w) begin
        err_q <= 1'b1;
      end
    end
  end

  dispbus_seq #(
    .ACK_TIMEOUT(ACK_TIMEOUT)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_w),
    .setup_cnt  (mode_q.setup),
    .width_cnt  (mode_q.width),
    .hold_cnt   (mode_q.hold),
    .nbytes     (nbytes_w),
    .ack_async  (mode_q.ack_async),
    .bus_ack    (bus_ack),
    .phase      (phase),
    .strobe_exit(strobe_exit_w),
    .byte_done  (byte_done_w),
    .xfer_done  (xfer_done_w),
    .abort      (abort_w)
  );

  dispbus_dpath u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_w),
    .is_read (start_w ? start_rd_w : rnw_q),
    .wdata   (data_wdata),
    .swap    (mode_q.swap),
    .nbytes  (nbytes_w),
    .capture (strobe_exit_w),
    .shift   (byte_done_w),
    .done    (xfer_done_w),
    .bus_din (bus_din),
    .bus_dout(bus_dout),
    .rdata   (data_rdata)
  );

  assign err        = err_q;
  assign bus_slave  = mode_q.slave;
  assign bus_regsel = mode_q.regsel;
  assign bus_rnw    = rnw_q;
  assign bus_cs     = (phase == PH_STROBE) && (mode_q.slave != SLAVE_RSVD);

endmodule

// File: rtl/dispbus_master_chk.sv
module dispbus_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       err,
  input logic       bus_cs,
  input logic [3:0] bus_slave,
  input logic       bus_rnw,
  input logic [7:0] bus_dout,
  input logic       bus_ack,
  input logic       async_mode
);

  // R7
  reserved_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs |-> (bus_slave != 4'hF));

  // R10
  cs_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs |-> busy);

  // R10
  slave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bus_slave));

  // R11
  rnw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bus_rnw));

  // R11
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && $past(bus_cs)) |-> $stable(bus_dout));

  // R8
  ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_cs) && async_mode && !err) |-> $past(bus_ack));

  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

endmodule

bind dispbus_master dispbus_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .err       (err),
  .bus_cs    (bus_cs),
  .bus_slave (bus_slave),
  .bus_rnw   (bus_rnw),
  .bus_dout  (bus_dout),
  .bus_ack   (bus_ack),
  .async_mode(async_mode)
);

// File: tb/tb_dispbus_master.sv
`timescale 1ns/1ps
module tb_dispbus_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [31:0] mode_wdata = '0;
  logic        data_we = 1'b0;
  logic [31:0] data_wdata = '0;
  logic        data_re = 1'b0;
  logic [31:0] data_rdata;
  logic        busy, err, bus_rnw, bus_cs;
  logic [3:0]  bus_slave;
  logic [2:0]  bus_regsel;
  logic [7:0]  bus_dout;
  logic [7:0]  bus_din = '0;
  logic        bus_ack = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dispbus_master dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .data_re(data_re),
    .data_rdata(data_rdata), .busy(busy), .err(err), .bus_slave(bus_slave),
    .bus_regsel(bus_regsel), .bus_rnw(bus_rnw), .bus_cs(bus_cs),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_ack(bus_ack)
  );

  // bench-side observation of the bus
  logic [7:0] rd_src [8];
  logic [7:0] cap    [8];
  logic [2:0] rs_cap [8];
  int  busy_n, pre_n, cs_rises, cs_run, cs_last_len;
  bit  seen_cs, rnw_seen, pbusy, pcs;
  bit  ack_en = 0;
  int  ack_dly = 1;

  always @(posedge clk) begin
    #1;
    if (busy && !pbusy) begin
      busy_n = 0; pre_n = 0; cs_rises = 0; seen_cs = 0; rnw_seen = 0;
    end
    if (busy) begin
      busy_n++;
      if (!bus_cs && !seen_cs) pre_n++;
      if (bus_rnw) rnw_seen = 1;
    end
    if (bus_cs) begin
      if (!pcs) begin
        cap[cs_rises & 7]    = bus_dout;
        rs_cap[cs_rises & 7] = bus_regsel;
        bus_din              = rd_src[cs_rises & 7];
        cs_rises++;
        cs_run  = 0;
        seen_cs = 1;
      end
      cs_run++;
      cs_last_len = cs_run;
      bus_ack = ack_en && (cs_run >= ack_dly);
    end else begin
      bus_ack = 1'b0;
    end
    pbusy = busy;
    pcs   = bus_cs;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int bsz, input bit pk, input bit inc, input int rs,
                                     input int sl, input bit asy, input int w, input int h,
                                     input int s, input bit sw);
    logic [31:0] m;
    m = 32'(bsz & 3) | (32'(pk) << 2) | (32'(inc) << 3) | (32'(rs & 7) << 4) |
        (32'(sl & 15) << 7) | (32'(asy) << 12) | (32'(w & 31) << 13) |
        (32'(h & 31) << 18) | (32'(s & 31) << 23) | (32'(sw) << 28);
    return m;
  endfunction

  task automatic set_mode(input logic [31:0] m);
    @(negedge clk); mode_we = 1'b1; mode_wdata = m;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk); data_we = 1'b1; data_wdata = d;
    @(negedge clk); data_we = 1'b0;
    wait_idle();
  endtask

  task automatic do_read();
    @(negedge clk); data_re = 1'b1;
    @(negedge clk); data_re = 1'b0;
    wait_idle();
  endtask

  task automatic t_reset();
    chk(busy == 0, "R1 busy", 32'(busy), 0);
    chk(err == 0, "R1 err", 32'(err), 0);
    chk(bus_cs == 0, "R1 cs", 32'(bus_cs), 0);
    chk(bus_rnw == 0, "R1 rnw", 32'(bus_rnw), 0);
    chk(data_rdata == 0, "R1 rdata", data_rdata, 0);
  endtask

  task automatic t_write_basic();
    set_mode(mk(3, 0, 0, 2, 2, 0, 2, 1, 1, 0));
    do_write(32'hAABBCCDD);
    chk(cs_rises == 3, "R2 three bytes", cs_rises, 3);
    chk(cap[0] == 8'hAA && cap[1] == 8'hBB && cap[2] == 8'hCC, "R3 msb first",
        {8'h0, cap[0], cap[1], cap[2]}, 32'hAABBCC);
    chk(pre_n == 2, "R5 setup length", pre_n, 2);
    chk(cs_last_len == 3, "R5 strobe length", cs_last_len, 3);
    chk(busy_n == 21, "R5 busy length", busy_n, 21);
    chk(bus_regsel == 2, "R6 no increment", 32'(bus_regsel), 2);
    chk(rnw_seen == 0, "R11 write direction", 32'(rnw_seen), 0);
    chk(data_rdata == 32'hAABBCCDD, "R10 data word", data_rdata, 32'hAABBCCDD);
  endtask

  task automatic t_width_pack();
    set_mode(mk(1, 0, 0, 0, 1, 0, 0, 0, 0, 0));
    do_write(32'h5A001122);
    chk(cs_rises == 1 && cap[0] == 8'h5A, "R2 one byte", {cs_rises[23:0], cap[0]}, 32'h15A);
    chk(busy_n == 3, "R5 minimal timing", busy_n, 3);
    set_mode(mk(1, 1, 0, 0, 1, 0, 0, 0, 0, 0));
    do_write(32'h01020304);
    chk(cs_rises == 4 && cap[3] == 8'h04, "R2 pack forces four", cs_rises, 4);
    set_mode(mk(0, 0, 0, 0, 1, 0, 0, 0, 0, 0));
    do_write(32'h01020304);
    chk(cs_rises == 4, "R2 code zero four bytes", cs_rises, 4);
  endtask

  task automatic t_swap_write();
    set_mode(mk(2, 0, 0, 0, 4, 0, 1, 0, 0, 1));
    do_write(32'hAABBCCDD);
    chk(cs_rises == 2 && cap[0] == 8'hDD && cap[1] == 8'hCC, "R3 swap order",
        {16'h0, cap[0], cap[1]}, 32'hDDCC);
  endtask

  task automatic t_read();
    rd_src[0] = 8'h12; rd_src[1] = 8'h34; rd_src[2] = 8'h56;
    set_mode(mk(2, 0, 0, 1, 6, 0, 1, 1, 0, 0));
    do_read();
    chk(data_rdata == 32'h12340000, "R4 top aligned", data_rdata, 32'h12340000);
    chk(rnw_seen == 1, "R11 read direction", 32'(rnw_seen), 1);
    set_mode(mk(2, 0, 0, 1, 6, 0, 1, 1, 0, 1));
    do_read();
    chk(data_rdata == 32'h00003412, "R4 swapped read", data_rdata, 32'h00003412);
    set_mode(mk(3, 0, 0, 1, 6, 0, 0, 0, 0, 0));
    do_read();
    chk(data_rdata == 32'h12345600, "R4 three byte read", data_rdata, 32'h12345600);
  endtask

  task automatic t_autoinc();
    set_mode(mk(3, 0, 1, 6, 3, 0, 0, 0, 0, 0));
    do_write(32'h01020300);
    chk(rs_cap[0] == 6 && rs_cap[1] == 7 && rs_cap[2] == 0, "R6 per-byte select",
        {rs_cap[0], rs_cap[1], rs_cap[2]}, 9'o670);
    chk(bus_regsel == 1, "R6 wrap after transfer", 32'(bus_regsel), 1);
  endtask

  task automatic t_reserved();
    set_mode(mk(2, 0, 0, 0, 15, 0, 1, 1, 1, 0));
    do_write(32'hFFEE0000);
    chk(cs_rises == 0, "R7 no chip select", cs_rises, 0);
    chk(busy_n == 12, "R7 timing still runs", busy_n, 12);
  endtask

  task automatic t_async();
    ack_en = 1; ack_dly = 6;
    set_mode(mk(1, 0, 0, 0, 5, 1, 2, 0, 0, 0));
    do_write(32'h77000000);
    chk(cs_last_len == 6, "R8 strobe stretched to ack", cs_last_len, 6);
    chk(err == 0, "R8 no error", 32'(err), 0);
    ack_en = 0;
  endtask

  task automatic t_timeout();
    set_mode(mk(1, 0, 0, 0, 5, 1, 1, 0, 0, 0));
    do_write(32'h99000000);
    chk(err == 1, "R9 error set", 32'(err), 1);
    chk(busy == 0 && bus_cs == 0, "R9 idle after abort", {busy, bus_cs}, 0);
    chk(cs_last_len == 65, "R9 abort point", cs_last_len, 65);
    set_mode(mk(1, 0, 0, 0, 5, 0, 0, 0, 0, 0));
    do_write(32'h11000000);
    chk(err == 0, "R9 error cleared by start", 32'(err), 0);
  endtask

  task automatic t_busy_ignore();
    set_mode(mk(1, 0, 0, 0, 3, 0, 1, 0, 10, 0));
    @(negedge clk); data_we = 1'b1; data_wdata = 32'h11223344;
    @(negedge clk); data_we = 1'b0;
    @(negedge clk); mode_we = 1'b1; mode_wdata = mk(2, 0, 0, 0, 5, 0, 0, 0, 0, 0);
    data_we = 1'b1; data_wdata = 32'h55667788; data_re = 1'b1;
    @(negedge clk); mode_we = 1'b0; data_we = 1'b0; data_re = 1'b0;
    chk(busy == 1, "R10 busy during transfer", 32'(busy), 1);
    wait_idle();
    chk(bus_slave == 3, "R10 mode write ignored", 32'(bus_slave), 3);
    chk(data_rdata == 32'h11223344, "R10 data write ignored", data_rdata, 32'h11223344);
    chk(cs_rises == 1 && cap[0] == 8'h11, "R10 single transfer", cs_rises, 1);
    chk(busy == 0, "R10 busy low after", 32'(busy), 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rd_src[i] = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_basic();
    t_width_pack();
    t_swap_write();
    t_read();
    t_autoinc();
    t_reserved();
    t_async();
    t_timeout();
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule